// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one or two independent pulse-width modulated outputs, each set up through a small word-addressed register bank. Each channel has three registers. The control register holds a 6-bit clock divider and a stop-mode bit. The duty register holds a 10-bit high-time count and a flag that forces the output high for the whole period. The period register holds a 10-bit period count.

The input clock is divided by (divider+1) to make a counter tick. The tick advances a period counter from 0 to the period count, and the output is high while that counter is below the high-time count. A per-channel enable input starts and stops a channel. When a channel stops, it either cuts the current period at the next clock or lets the period finish, depending on the stop-mode bit.

The register port is a plain single-cycle write strobe with a combinational read. There is no stream data path, so the port has no valid/ready handshake.

Top module: `pwm_prescaled`

## Requirements
- R1: Registers are word addressed and address bits [1:0] are ignored. Address bit 4 selects the channel, so channel 1 sits at base 0x10. Bits [3:2] select the register: 0 is control, 1 is duty, 2 is period. A write strobed in one cycle is visible from the next clock edge.
- R2: `reg_rdata` shows, in the same cycle, the stored fields of the addressed register with every unused bit at 0. The fields are: control, divider in bits [5:0] and stop mode in bit 6; duty, high-time count in bits [9:0] and full-high flag in bit 10; period, count in bits [9:0]. Register index 3 reads 0, and so does channel 1 when only one channel is built.
- R3: While a channel runs, one period lasts (divider+1)*(period+1) input clocks.
- R4: The output is active high. Each period begins with (divider+1)*highcount clocks high, then stays low for the rest of the period.
- R5: When the full-high flag is set, the output is high for the whole period, whatever the high-time count.
- R6: A high-time count of 0 with the flag clear gives a constantly low output. A count of period+1 or more gives a constantly high output.
- R7: The divider, high-time count, flag and period count take effect only at the start of a period. A write during a period does not change that period.
- R8: With stop-mode bit 6 set, sampling the enable low while running stops the channel at that clock edge. The output goes low and the next start begins a fresh period.
- R9: With stop-mode bit 6 clear, a running channel whose enable is low finishes its current period, then goes idle with the output low. If the enable is high again at the period end, the channel keeps running.
- R10: Reset clears all registers, the counters and the outputs to 0.
- R11: An idle channel that samples its enable high begins a period at that clock edge, using the register values held at that time.
- R12: Channels are independent. Writes, enables and stops on one channel never affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| chan_en | input | NUM_CH | Per-channel run enable |
| pwm_out | output | NUM_CH | Per-channel PWM output |

## Verification
The hardest situations to reach are a register write that lands in the middle of a running period, and a stop request that lands in the middle of a period. The write must be held off until the boundary. The stop must either cut the period or let it finish, depending on a bit that can itself change. The stimulus rewrites the duty and period registers several clocks into a running period, and drops the enable partway through a period with each stop mode. It also re-raises the enable before a graceful stop has finished. Meanwhile the second channel runs a different configuration, so any cross-talk between channels shows up in the comparison.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int DIV_W   = 6;
  parameter int CNT_W   = 10;
  parameter int ADDR_W  = 5;
  parameter int DATA_W  = 32;
  localparam int STOP_BIT = DIV_W;
  localparam int FULL_BIT = CNT_W;
  localparam int CTRL_W   = DIV_W + 1;
  localparam int DUTY_W   = CNT_W + 1;
  localparam int CH_BIT   = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_PER  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              stop_abrupt_o,
  output logic [CNT_W-1:0]  high_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DUTY_W-1:0] duty_q;
  logic [CNT_W-1:0]  per_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:DUTY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
        SEL_DUTY: duty_q <= wdata_i[DUTY_W-1:0];
        SEL_PER:  per_q  <= wdata_i[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  assign div_o         = ctrl_q[DIV_W-1:0];
  assign stop_abrupt_o = ctrl_q[STOP_BIT];
  assign high_o        = duty_q[CNT_W-1:0];
  assign full_o        = duty_q[FULL_BIT];
  assign per_o         = per_q;

  always_comb begin
    case (sel_i)
      SEL_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      SEL_DUTY: rdata_o = {{(DATA_W-DUTY_W){1'b0}}, duty_q};
      SEL_PER:  rdata_o = {{(DATA_W-CNT_W){1'b0}}, per_q};
      default:  rdata_o = '0;
    endcase
  end

  // R1: a write is held from the next edge
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_CTRL) |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
  a_r1_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_PER) |=> per_q == $past(wdata_i[CNT_W-1:0]));
  // R12: no write strobe, no change
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_q) && $stable(duty_q) && $stable(per_q));
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             stop_abrupt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             full_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             pwm_o
);
  logic             running;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] per_cnt;
  logic [DIV_W-1:0] act_div;
  logic [CNT_W-1:0] act_high;
  logic             act_full;
  logic [CNT_W-1:0] act_per;
  logic             tick;
  logic             period_end;
  logic             cut;

  assign tick       = (div_cnt == act_div);
  assign period_end = running && tick && (per_cnt == act_per);
  assign cut        = running && !en_i && stop_abrupt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      div_cnt  <= '0;
      per_cnt  <= '0;
      act_div  <= '0;
      act_high <= '0;
      act_full <= 1'b0;
      act_per  <= '0;
    end else if (!running) begin
      div_cnt <= '0;
      per_cnt <= '0;
      if (en_i) begin
        running  <= 1'b1;
        act_div  <= div_i;
        act_high <= high_i;
        act_full <= full_i;
        act_per  <= per_i;
      end
    end else if (cut) begin
      running <= 1'b0;
      div_cnt <= '0;
      per_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      if (per_cnt == act_per) begin
        per_cnt <= '0;
        if (en_i) begin
          act_div  <= div_i;
          act_high <= high_i;
          act_full <= full_i;
          act_per  <= per_i;
        end else begin
          running <= 1'b0;
        end
      end else begin
        per_cnt <= per_cnt + 1'b1;
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign pwm_o = running && (act_full || (per_cnt < act_high));

  // R3: counters never pass the latched limits
  a_r3_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (div_cnt <= act_div) && (per_cnt <= act_per));
  // R7: latched settings stay fixed inside a period
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_end) |=> $stable(act_div) && $stable(act_high)
      && $stable(act_full) && $stable(act_per));
  // R8: an abrupt stop drops the output on the next edge
  a_r8_abrupt_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cut |=> !pwm_o && !running);
  // R9: a graceful stop keeps the period going
  a_r9_graceful: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !en_i && !stop_abrupt_i && !period_end) |=> running);
  // R11: an enabled idle channel starts at once
  a_r11_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && en_i) |=> running);
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] pwm_out
);
  reg_sel_e          sel;
  logic              ch_sel;
  logic [DATA_W-1:0] ch_rd [NUM_CH];
  logic              unused_addr;

  assign sel         = reg_sel_e'(reg_addr[3:2]);
  assign ch_sel      = reg_addr[CH_BIT];
  assign unused_addr = ^reg_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DIV_W-1:0] div;
    logic             stop_abrupt;
    logic [CNT_W-1:0] high;
    logic             full;
    logic [CNT_W-1:0] per;

    pwm_chan_regs u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (reg_wr && (ch_sel == 1'(c))),
      .sel_i        (sel),
      .wdata_i      (reg_wdata),
      .div_o        (div),
      .stop_abrupt_o(stop_abrupt),
      .high_o       (high),
      .full_o       (full),
      .per_o        (per),
      .rdata_o      (ch_rd[c])
    );

    pwm_chan_core u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (chan_en[c]),
      .stop_abrupt_i(stop_abrupt),
      .div_i        (div),
      .high_i       (high),
      .full_i       (full),
      .per_i        (per),
      .pwm_o        (pwm_out[c])
    );
  end

  if (NUM_CH > 1) begin : g_rd2
    assign reg_rdata = ch_sel ? ch_rd[1] : ch_rd[0];
  end else begin : g_rd1
    assign reg_rdata = ch_sel ? '0 : ch_rd[0];
  end

  // R10: outputs are low straight after reset
  a_r10_reset_low: assert property (@(posedge clk)
    $rose(rst_n) |-> pwm_out == '0);
endmodule

// File: tb/sim_pwm_prescaled.sv
module sim_pwm_prescaled;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  chan_en = '0;
  logic [1:0]  pwm_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference model state
  int m_ctrl [NCH];
  int m_duty [NCH];
  int m_per  [NCH];
  int m_run  [NCH];
  int m_t    [NCH];
  int l_div  [NCH];
  int l_high [NCH];
  int l_full [NCH];
  int l_per  [NCH];

  pwm_prescaled #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_en(chan_en), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_ctrl[c] = 0; m_duty[c] = 0; m_per[c] = 0; m_run[c] = 0; m_t[c] = 0;
      l_div[c] = 0; l_high[c] = 0; l_full[c] = 0; l_per[c] = 0;
    end
  end

  function automatic void latch(int c);
    l_div[c]  = m_ctrl[c] & 63;
    l_high[c] = m_duty[c] & 1023;
    l_full[c] = (m_duty[c] >> 10) & 1;
    l_per[c]  = m_per[c] & 1023;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = 0; m_duty[c] = 0; m_per[c] = 0; m_run[c] = 0; m_t[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int len;
        len = (l_div[c] + 1) * (l_per[c] + 1);
        if (m_run[c] == 0) begin
          if (chan_en[c]) begin m_run[c] = 1; m_t[c] = 0; latch(c); end
        end else if (!chan_en[c] && ((m_ctrl[c] >> 6) & 1) == 1) begin
          m_run[c] = 0; m_t[c] = 0;
        end else if (m_t[c] == len - 1) begin
          m_t[c] = 0;
          if (chan_en[c]) latch(c); else m_run[c] = 0;
        end else begin
          m_t[c]++;
        end
      end
      if (reg_wr) begin
        int ch;
        ch = reg_addr[4];
        case (reg_addr[3:2])
          2'd0: m_ctrl[ch] = reg_wdata & 32'h7F;
          2'd1: m_duty[ch] = reg_wdata & 32'h7FF;
          2'd2: m_per[ch]  = reg_wdata & 32'h3FF;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int ch;
      int exp_rd;
      for (int c = 0; c < NCH; c++) begin
        bit exp_o;
        exp_o = (m_run[c] != 0) &&
                (l_full[c] != 0 || m_t[c] < (l_div[c] + 1) * l_high[c]);
        compared++;
        if (pwm_out[c] !== exp_o) begin
          mismatched++;
          $display("FAIL %s ch%0d pwm_out actual=%0b expected=%0b t=%0t",
                   cur_req, c, pwm_out[c], exp_o, $time);
        end
      end
      ch = reg_addr[4];
      case (reg_addr[3:2])
        2'd0: exp_rd = m_ctrl[ch];
        2'd1: exp_rd = m_duty[ch];
        2'd2: exp_rd = m_per[ch];
        default: exp_rd = 0;
      endcase
      compared++;
      if (reg_rdata !== 32'(exp_rd)) begin
        mismatched++;
        $display("FAIL R2 reg_rdata addr=%h actual=%h expected=%h",
                 reg_addr, reg_rdata, exp_rd);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    step(3);
    cur_req = "R10"; // reset state, including reads of every register
    for (int a = 0; a < 32; a += 4) begin reg_addr = 5'(a); step(1); end
    rst_n = 1'b1;
    step(2);

    cur_req = "R2"; // field masking and unmapped reads
    wr(5'h10, 32'hFFFF_FFFF); reg_addr = 5'h10; step(1);
    wr(5'h14, 32'hFFFF_FFFF); reg_addr = 5'h14; step(1);
    wr(5'h18, 32'hFFFF_FFFF); reg_addr = 5'h18; step(1);
    reg_addr = 5'h1C; step(1);
    reg_addr = 5'h0E; step(1);

    cur_req = "R1"; // channel 0 map: divide 2, high 3, period 6
    wr(5'h00, 32'h1); wr(5'h05, 32'h3); wr(5'h0B, 32'h5);
    wr(5'h10, 32'h0); wr(5'h14, 32'h2); wr(5'h18, 32'h4);
    reg_addr = 5'h04;

    cur_req = "R11"; chan_en = 2'b01; step(2);
    cur_req = "R4";  step(30);
    cur_req = "R3";  step(20);

    cur_req = "R12"; chan_en = 2'b11; step(15);

    cur_req = "R7"; // rewrite mid-period
    step(3); wr(5'h04, 32'h5); wr(5'h08, 32'h7); step(40);

    cur_req = "R5"; wr(5'h04, 32'h400 | 32'h1); step(40);
    cur_req = "R6"; wr(5'h04, 32'h0); step(40);
    wr(5'h04, 32'd20); step(40);
    wr(5'h04, 32'd8); step(40); // count equal to period+1

    cur_req = "R9"; // graceful stop, mid period
    wr(5'h04, 32'h3); step(25);
    chan_en[0] = 1'b0; step(40);
    chan_en[0] = 1'b1; step(5);
    chan_en[0] = 1'b0; step(3);
    chan_en[0] = 1'b1; step(30); // re-enabled before the period ends

    cur_req = "R8"; // abrupt stop
    wr(5'h00, 32'h41); step(7);
    chan_en[0] = 1'b0; step(10);
    chan_en[0] = 1'b1; step(20);
    wr(5'h10, 32'h40); step(4);
    chan_en[1] = 1'b0; step(10);
    chan_en[1] = 1'b1; step(12);

    cur_req = "R12"; wr(5'h18, 32'h1); reg_addr = 5'h18; step(30);
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    finish_run();
  end
endmodule